// File: doc/BRIEF.md
# Board interrupt level encoder

This block sits on a board-control bus. It collects thirteen level-sensitive interrupt lines from on-board peripherals and turns them into one 4-bit priority code for the CPU. Each line passes through a synchronizer and then drives one bit of a 16-bit status word. Which bit a line drives is fixed. A software-written 16-bit enable word gates the status word. The highest-priority enabled line then sets the code. Priority is fixed: the lowest level number wins.

A small window of 16-bit registers is also reachable through the same synchronous bus. It holds the enable word, a general-purpose output port and a constant version word. It also holds a power-off command that produces a one-cycle shutdown request.

Top module: `irl_board_ctrl`

## Requirements
- R1: Each source's status bit follows the synchronized input level with no latching: when a source drops, it stops contributing.
- R2: A source takes part in the priority decision only when its status bit and the enable bit at the same position are both 1. With an all-zero enable word, `irl_o` is 0.
- R3: Source `src_i[k]` has priority level k, and the lowest level among the participating sources wins. The status/enable bit of level k is, for k = 0..12: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. Bits 1, 2 and 3 are stored in the enable word but gate nothing.
- R4: `irl_o` equals the winning level XOR 15. With no participating source the level is 15, so `irl_o` is 0. Level 0 gives 15.
- R5: A change on `src_i` first shows on `irl_o` after the third rising edge that follows it. A write to the enable word shows on `irl_o` after the second rising edge from the write's setup, which is one edge after the write is captured.
- R6: Offset 0x00 holds the enable word, readable and writable. It resets to 0.
- R7: Offset 0x36 holds the output port. It is readable and writable, is driven on `port_o`, and resets to 0. Only a write to 0x36 changes it.
- R8: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R9: Offset 0x30 reads 0. A write to it with data bit 0 set makes `shutdown_o` high for exactly the one cycle after the write edge. A write with bit 0 clear makes no pulse.
- R10: Reads from any other offset (odd addresses included) return 0. Writes to them change neither the enable word nor the port.
- R11: After reset, `irl_o`, `port_o` and `shutdown_o` are 0.
- R12: Read data is registered. `bus_rdata` shows the addressed word after the edge that samples `bus_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 13 | Interrupt lines, index = priority level |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irl_o | output | 4 | Inverted winning priority level |
| port_o | output | 16 | General output port |
| shutdown_o | output | 1 | One-cycle shutdown request |

## Verification
Each result has its own due cycle, counted in rising edges from the cycle the stimulus is set up:
- read data, port value and shutdown pulse are due after one edge;
- a new enable word reaches the code after two edges;
- a source change reaches the code after three edges.

The bench drives inputs on falling edges. Each stimulus task queues its expected values tagged with that absolute due cycle. A falling-edge monitor compares every queued item exactly in its due cycle. The value one edge before the due cycle is also queued in a few places, so an early result is caught as well as a late one.

// File: rtl/irlc_pkg.sv
package irlc_pkg;

   localparam int NUM_SRC = 13;
   localparam int WORD_W  = 16;
   localparam int LVL_W   = 4;
   localparam int OFS_W   = 6;

   localparam logic [OFS_W-1:0] OFS_ENABLE  = 6'h00;
   localparam logic [OFS_W-1:0] OFS_POWER   = 6'h30;
   localparam logic [OFS_W-1:0] OFS_VERSION = 6'h32;
   localparam logic [OFS_W-1:0] OFS_PORT    = 6'h36;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ENABLE,
      SEL_POWER,
      SEL_VERSION,
      SEL_PORT
   } reg_sel_e;

   // status/enable bit used by the source of priority level k
   function automatic int level_bit(input int k);
      case (k)
         0:       return 11;
         1:       return 9;
         2:       return 8;
         3:       return 12;
         4:       return 10;
         5:       return 6;
         6:       return 5;
         7:       return 4;
         8:       return 7;
         9:       return 14;
         10:      return 13;
         11:      return 0;
         12:      return 15;
         default: return 1;
      endcase
   endfunction

   function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] a);
      if (a == OFS_ENABLE)       return SEL_ENABLE;
      else if (a == OFS_POWER)   return SEL_POWER;
      else if (a == OFS_VERSION) return SEL_VERSION;
      else if (a == OFS_PORT)    return SEL_PORT;
      else                       return SEL_NONE;
   endfunction

endpackage

// File: rtl/irlc_sync.sv
module irlc_sync #(
   parameter int WIDTH  = 13,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/irlc_status_map.sv
module irlc_status_map
   import irlc_pkg::*;
#(
   parameter int N_SRC  = NUM_SRC,
   parameter int WORD_W_P = WORD_W
) (
   input  logic [N_SRC-1:0]    lvl_src_i,
   output logic [WORD_W_P-1:0] status_o
);

   always_comb begin
      status_o = '0;
      for (int k = 0; k < N_SRC; k++) begin
         status_o[level_bit(k)] = lvl_src_i[k];
      end
   end

endmodule

// File: rtl/irlc_prio_enc.sv
module irlc_prio_enc
   import irlc_pkg::*;
#(
   parameter int N_SRC    = NUM_SRC,
   parameter int WORD_W_P = WORD_W,
   parameter int LVL_W_P  = LVL_W,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [WORD_W_P-1:0] status_i,
   input  logic [WORD_W_P-1:0] enable_i,
   output logic [LVL_W_P-1:0]  code_o
);

   localparam logic [LVL_W_P-1:0] IDLE_LVL = '1;

   logic [WORD_W_P-1:0] live;
   logic [LVL_W_P-1:0]  win_lvl;
   logic [LVL_W_P-1:0]  code_d;

   assign live = status_i & enable_i;

   // scan from the weakest level up so the lowest live level is left last
   always_comb begin
      win_lvl = IDLE_LVL;
      for (int k = N_SRC - 1; k >= 0; k--) begin
         if (live[level_bit(k)]) win_lvl = LVL_W_P'(k);
      end
   end

   assign code_d = win_lvl ^ IDLE_LVL;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) code_o <= '0;
            else        code_o <= code_d;
         end
      end else begin : g_comb
         assign code_o = code_d;
      end
   endgenerate

endmodule

// File: rtl/irlc_regs.sv
module irlc_regs
   import irlc_pkg::*;
#(
   parameter int               WORD_W_P = WORD_W,
   parameter int               OFS_W_P  = OFS_W,
   parameter logic [WORD_W-1:0] VERSION = 16'h0010
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [OFS_W_P-1:0]  addr_i,
   input  logic                wr_i,
   input  logic                rd_i,
   input  logic [WORD_W_P-1:0] wdata_i,
   output logic [WORD_W_P-1:0] rdata_o,
   output logic [WORD_W_P-1:0] enable_o,
   output logic [WORD_W_P-1:0] port_o,
   output logic                shutdown_o
);

   reg_sel_e            sel;
   logic [WORD_W_P-1:0] rd_mux;

   assign sel = decode_ofs(addr_i);

   always_comb begin
      case (sel)
         SEL_ENABLE:  rd_mux = enable_o;
         SEL_PORT:    rd_mux = port_o;
         SEL_VERSION: rd_mux = VERSION;
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_o   <= '0;
         port_o     <= '0;
         shutdown_o <= 1'b0;
         rdata_o    <= '0;
      end else begin
         shutdown_o <= wr_i && (sel == SEL_POWER) && wdata_i[0];
         if (wr_i && sel == SEL_ENABLE) enable_o <= wdata_i;
         if (wr_i && sel == SEL_PORT)   port_o   <= wdata_i;
         if (rd_i)                      rdata_o  <= rd_mux;
      end
   end

endmodule

// File: rtl/irl_board_ctrl.sv
module irl_board_ctrl
   import irlc_pkg::*;
#(
   parameter int               N_SRC       = NUM_SRC,
   parameter int               SYNC_STAGES = 2,
   parameter bit               REG_OUT     = 1'b1,
   parameter logic [WORD_W-1:0] VERSION    = 16'h0010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic [OFS_W-1:0]  bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic [LVL_W-1:0]  irl_o,
   output logic [WORD_W-1:0] port_o,
   output logic              shutdown_o
);

   localparam int MAX_SRC = (1 << LVL_W) - 1;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (N_SRC > MAX_SRC || N_SRC > NUM_SRC) begin : g_bad_src
         $error("N_SRC exceeds the level code range or the bit table");
      end
   endgenerate

   logic [N_SRC-1:0]  src_sync;
   logic [WORD_W-1:0] status;
   logic [WORD_W-1:0] enable;

   irlc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (src_sync)
   );

   irlc_status_map #(.N_SRC(N_SRC), .WORD_W_P(WORD_W)) u_map (
      .lvl_src_i (src_sync),
      .status_o  (status)
   );

   irlc_regs #(.WORD_W_P(WORD_W), .OFS_W_P(OFS_W), .VERSION(VERSION)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (bus_addr),
      .wr_i       (bus_wr),
      .rd_i       (bus_rd),
      .wdata_i    (bus_wdata),
      .rdata_o    (bus_rdata),
      .enable_o   (enable),
      .port_o     (port_o),
      .shutdown_o (shutdown_o)
   );

   irlc_prio_enc #(.N_SRC(N_SRC), .WORD_W_P(WORD_W), .LVL_W_P(LVL_W),
                   .REG_OUT(REG_OUT)) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .status_i (status),
      .enable_i (enable),
      .code_o   (irl_o)
   );

endmodule

// File: rtl/irlc_checker.sv
module irlc_checker
   import irlc_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic [OFS_W-1:0]  bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [WORD_W-1:0] bus_wdata,
   input logic [WORD_W-1:0] bus_rdata,
   input logic [LVL_W-1:0]  irl_o,
   input logic [WORD_W-1:0] port_o,
   input logic              shutdown_o
);

   logic known_ofs;
   assign known_ofs = (bus_addr == OFS_ENABLE) || (bus_addr == OFS_POWER) ||
                      (bus_addr == OFS_VERSION) || (bus_addr == OFS_PORT);

   AST_SHUTDOWN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_o |=> !shutdown_o); // R9

   AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_POWER && bus_wdata[0]) |=> shutdown_o); // R9

   AST_POWER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_POWER) |=> (bus_rdata == '0)); // R9

   AST_VERSION_CONST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_VERSION) |=> (bus_rdata == 16'h0010)); // R8

   AST_UNLISTED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !known_ofs) |=> (bus_rdata == '0)); // R10

   AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == OFS_PORT) |=> $stable(port_o)); // R7

   AST_ENABLE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_ENABLE && bus_wdata == '0) |=> ##1 (irl_o == '0)); // R2

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R12

endmodule

bind irl_board_ctrl irlc_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .irl_o      (irl_o),
   .port_o     (port_o),
   .shutdown_o (shutdown_o)
);

// File: tb/irl_board_ctrl_test.sv
`timescale 1ns/1ps
module irl_board_ctrl_test;

   localparam int K_IRL = 0, K_RD = 1, K_PORT = 2, K_SHUT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] src_i = '0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  irl_o;
   logic [15:0] port_o;
   logic        shutdown_o;

   always #2 clk = ~clk;

   irl_board_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irl_o(irl_o), .port_o(port_o),
      .shutdown_o(shutdown_o)
   );

   typedef struct {
      int          due;
      int          kind;
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t sb[$];
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;

   logic [15:0] m_enable = '0;
   logic [12:0] m_src = '0;

   int bit_of [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [15:0] model_irl(input logic [12:0] s, input logic [15:0] en);
      int lvl = 15;
      for (int k = 12; k >= 0; k--) if (s[k] && en[bit_of[k]]) lvl = k;
      return 16'(lvl ^ 15);
   endfunction

   task automatic push(input int dly, input int kind, input logic [15:0] exp, input string req);
      item_t it;
      it.due = cyc + dly; it.kind = kind; it.exp = exp; it.req = req;
      sb.push_back(it);
   endtask

   // monitor: compares every queued item in its due cycle
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due <= cyc) begin
            logic [15:0] act;
            case (sb[i].kind)
               K_IRL:   act = {12'd0, irl_o};
               K_RD:    act = bus_rdata;
               K_PORT:  act = port_o;
               default: act = {15'd0, shutdown_o};
            endcase
            checks++;
            if (sb[i].due != cyc || act !== sb[i].exp) begin
               errors++;
               $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                        sb[i].req, sb[i].kind, cyc, act, sb[i].exp);
            end
            sb.delete(i);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [15:0] d, input string req);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      if (a == 6'h00) begin
         push(1, K_IRL, model_irl(m_src, m_enable), "R5 early");
         m_enable = d;
         push(2, K_IRL, model_irl(m_src, m_enable), req);
      end
      if (a == 6'h36) push(1, K_PORT, d, req);
      if (a == 6'h30) begin
         push(1, K_SHUT, {15'd0, d[0]}, req);
         push(2, K_SHUT, 16'd0, req);
      end
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, input logic [15:0] exp, input string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      push(1, K_RD, exp, req);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_src(input logic [12:0] v, input string req);
      @(negedge clk);
      push(2, K_IRL, model_irl(m_src, m_enable), "R5 early");
      src_i = v; m_src = v;
      push(3, K_IRL, model_irl(m_src, m_enable), req);
      idle(4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      push(1, K_IRL, 16'd0, "R11");
      push(1, K_PORT, 16'd0, "R11");
      push(1, K_SHUT, 16'd0, "R11");
      idle(2);
      bus_read(6'h00, 16'h0000, "R6 reset");
      // R8 version constant
      bus_read(6'h32, 16'h0010, "R8");
      bus_write(6'h32, 16'hBEEF, "R8");
      bus_read(6'h32, 16'h0010, "R8 after write");
      // R6 enable word
      bus_write(6'h00, 16'hFFFF, "R6 R5");
      bus_read(6'h00, 16'hFFFF, "R6");
      // R3 R4 each source alone
      for (int k = 0; k < 13; k++) begin
         set_src(13'(1 << k), "R3 R4 single");
      end
      set_src('0, "R1 drop");
      set_src(13'h1FFF, "R4 level0");
      set_src(13'(1 << 5) | 13'(1 << 9), "R3 pair");
      // R2 gating: clear level-5 bit (bit 6)
      bus_write(6'h00, 16'hFFBF, "R2 mask");
      bus_write(6'h00, 16'h000E, "R2 unused bits");
      bus_write(6'h00, 16'h4000, "R2 only level9");
      set_src(13'h1DFF, "R2 gated off");
      set_src(13'h1FFF, "R2 level9 wins");
      bus_write(6'h00, 16'h0000, "R2 all off");
      bus_write(6'h00, 16'hFFFF, "R5 enable");
      set_src('0, "R1 no latch");
      // R7 port
      bus_write(6'h36, 16'hA5C3, "R7");
      bus_read(6'h36, 16'hA5C3, "R7 readback");
      // R9 power
      bus_write(6'h30, 16'h0001, "R9 pulse");
      bus_write(6'h30, 16'hFFFE, "R9 no pulse");
      bus_read(6'h30, 16'h0000, "R9 read");
      // R10 unlisted
      bus_write(6'h02, 16'h1234, "R10");
      bus_write(6'h37, 16'h5555, "R10");
      bus_read(6'h02, 16'h0000, "R10 read");
      bus_read(6'h34, 16'h0000, "R10 read");
      bus_read(6'h01, 16'h0000, "R10 odd");
      bus_read(6'h00, 16'hFFFF, "R10 enable kept");
      bus_read(6'h36, 16'hA5C3, "R10 port kept");
      // R12 rdata holds without read strobe
      idle(2);
      push(1, K_RD, 16'hA5C3, "R12 hold");
      idle(4);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule